// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block gives a processor three independent 16-bit down counters. Each counter has its own count-enable tick, gate and output pin, and all three share one byte-wide bus. The bus has a 2-bit address, separate write and read strobes and a read-data return. Software writes a control byte to pick a counter, the order in which that counter's bytes move over the bus, and its operating mode. It then writes the initial count through the counter's data port. The count can be read while it runs. A latch command freezes a copy of the count, so that a two-byte read is consistent even though counting goes on.

Three operating behaviours are supported: a one-time terminal-count event, a periodic one-tick strobe, and a square wave. Each runs in plain binary or in four-digit decimal. The counter ticks are enables sampled on the system clock, so the whole block sits in one clock domain. An upstream synchroniser or divider produces the ticks.

Top module: `pit_timer`

## Requirements
- R1: Addresses 0, 1 and 2 are the data ports of counters 0, 1 and 2, and address 3 is the control port. Reading address 3 returns 0x00. After reset every output pin is high, every count is zero and every data port reads 0x00.
- R2: In a control byte, bits 7:6 select the counter (00, 01, 10); the value 11 makes the whole byte have no effect. Bits 3:1 hold the mode code. Code 0 is the terminal-count event, 2 or 6 is the periodic strobe, 3 or 7 is the square wave. A byte carrying code 1, 4 or 5 leaves the counter's output, count and access pattern untouched. Bit 0 set selects decimal counting.
- R3: Control bits 5:4 pick the byte access: 01 is low byte only (high byte loads as zero), 10 is high byte only (low byte loads as zero), 11 is low byte then high byte over two transfers. Reads follow the same pattern, and the low-only and high-only patterns never alternate.
- R4: A control byte with a non-zero access field returns the write and read byte order to the low byte, drops any held snapshot and stops the counter until a new count is complete.
- R5: A count takes effect only once its last byte is written, and it enters the counter on the first tick after that write.
- R6: A control byte with access 00 freezes the present count for reads of that counter, while counting continues. Further freeze commands are ignored until the frozen value has been read in full, after which reads follow the live count.
- R7: In terminal-count mode the output goes low one clock after the control byte is written. It goes high on the tick that takes the count from 1 to 0, that is the N+1th tick after the count is complete (N is the count), and stays high. A low gate holds the count still.
- R8: In periodic strobe mode the output goes low on the tick that takes the count from 2 to 1. The next tick restores the initial count and drives the output high, giving a period of N ticks with one tick low.
- R9: In square-wave mode the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, in each radix.
- R10: In the periodic and square-wave modes, a low gate drives the output high one clock later and holds the count. The first tick after the gate is high again restores the initial count.
- R11: In decimal mode each 4-bit digit counts 9 down to 0, and 0000 steps to 9999. A loaded count of 0 stands for 10000 decimal or 65536 binary.
- R12: Without a tick on its counter, a bus write or a change of its gate, an output pin holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Port select: 0 to 2 data, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe; advances byte order and snapshot release |
| bus_rdata | output | 8 | Read data for the addressed port |
| cnt_tick | input | NUM_CH | Per-counter count enable, one count per clock it is high |
| cnt_gate | input | NUM_CH | Per-counter gate |
| cnt_out | output | NUM_CH | Per-counter output pin |

## Verification
The bench builds the block with its default of three counters and 16-bit counts. Every counter select and address 3 therefore decode to real ports, and the unused select 11 can be written to show that it has no effect. A 16-bit count gives four decimal digits, so the wrap from 0000 to 9999 and the halving of a decimal count for the square wave are both reached with short counts. A count of 0x1234 in the latch sequence makes its two bytes, and the gap between the frozen and live values, easy to tell apart.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
// pit_pkg: shared widths, control-field types and count arithmetic for the
// interval timer. Assumes a byte bus and a count of two bytes (four digits).
package pit_pkg;

    localparam int BUS_W  = 8;
    localparam int CNT_W  = 2 * BUS_W;
    localparam int DIGITS = CNT_W / 4;

    typedef enum logic [1:0] {
        ACC_FREEZE = 2'b00,
        ACC_LO     = 2'b01,
        ACC_HI     = 2'b10,
        ACC_WORD   = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        MD_EVENT  = 2'd0,
        MD_STROBE = 2'd1,
        MD_SQUARE = 2'd2
    } mode_e;

    // Mode codes this block supports: 0, 2, 3, 6, 7.
    function automatic logic mode_supported(input logic [2:0] code);
        return (code == 3'd0) || code[1];
    endfunction

    function automatic mode_e mode_from_code(input logic [2:0] code);
        if (code == 3'd0) return MD_EVENT;
        return code[0] ? MD_SQUARE : MD_STROBE;
    endfunction

    // One step down, binary or per-digit decimal with borrow.
    function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] v,
                                                    input logic dec);
        logic [CNT_W-1:0] r;
        logic             borrow;
        r      = v;
        borrow = 1'b1;
        if (!dec) begin
            r = v - 1'b1;
        end else begin
            for (int d = 0; d < DIGITS; d++) begin
                if (borrow) begin
                    if (v[d*4 +: 4] == 4'd0) begin
                        r[d*4 +: 4] = 4'd9;
                    end else begin
                        r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
                        borrow      = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction

    // Floor of half the loaded count; zero stands for the full range.
    function automatic logic [CNT_W-1:0] count_half(input logic [CNT_W-1:0] v,
                                                    input logic dec);
        logic [CNT_W-1:0] r;
        logic             carry;
        logic [3:0]       dig;
        r     = '0;
        carry = (v == '0);
        if (!dec) begin
            r = carry ? {1'b1, {(CNT_W-1){1'b0}}} : (v >> 1);
        end else begin
            for (int d = DIGITS - 1; d >= 0; d--) begin
                dig         = v[d*4 +: 4];
                r[d*4 +: 4] = (dig >> 1) + (carry ? 4'd5 : 4'd0);
                carry       = dig[0];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pit_bus_decode.sv
`timescale 1ns/1ps
// pit_bus_decode: turns one bus transfer into per-counter strobes and the
// decoded control fields. Purely combinational. Assumes at most one of
// bus_wr / bus_rd per cycle; control bytes with an unused select or an
// unsupported mode code raise no strobe at all.
module pit_bus_decode
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [NUM_CH-1:0] cfg_wr,
    output logic [NUM_CH-1:0] freeze_cmd,
    output logic [NUM_CH-1:0] data_wr,
    output logic [NUM_CH-1:0] data_rd,
    output acc_e              cfg_acc,
    output mode_e             cfg_mode,
    output logic              cfg_dec
);

    localparam logic [1:0] CTRL_ADDR = 2'd3;

    logic       ctrl_hit;
    logic [2:0] mode_code;

    // Field extraction shared by every counter.
    always_comb begin
        ctrl_hit  = bus_wr && (bus_addr == CTRL_ADDR);
        mode_code = bus_wdata[3:1];
        cfg_acc   = acc_e'(bus_wdata[5:4]);
        cfg_mode  = mode_from_code(mode_code);
        cfg_dec   = bus_wdata[0];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel_me;
        // Per-counter strobes for control, freeze, data write and data read.
        always_comb begin
            sel_me        = ctrl_hit && (bus_wdata[7:6] == 2'(g));
            cfg_wr[g]     = sel_me && (cfg_acc != ACC_FREEZE) && mode_supported(mode_code);
            freeze_cmd[g] = sel_me && (cfg_acc == ACC_FREEZE);
            data_wr[g]    = bus_wr && (bus_addr == 2'(g));
            data_rd[g]    = bus_rd && (bus_addr == 2'(g));
        end
    end

endmodule

// File: rtl/pit_byte_port.sv
`timescale 1ns/1ps
// pit_byte_port: the byte-serial face of one counter. Holds the access
// pattern, the write and read byte-order flops, the staged low byte and
// the frozen snapshot. Produces a one-cycle load request with the full
// new count when its last byte arrives, and the byte to return on a read.
module pit_byte_port
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  acc_e             cfg_acc,
    input  logic             freeze_cmd,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic [BUS_W-1:0] wdata,
    input  logic [CNT_W-1:0] live_cnt,
    output logic             load_req,
    output logic [CNT_W-1:0] load_val,
    output logic [BUS_W-1:0] rd_byte
);

    acc_e             acc_q;
    logic             wr_hi_q;
    logic             rd_hi_q;
    logic [BUS_W-1:0] lo_stage_q;
    logic             frozen_q;
    logic [CNT_W-1:0] snap_q;
    logic [CNT_W-1:0] rd_src;
    logic             rd_upper;

    // Count assembly for the current pattern and the last-byte detect.
    always_comb begin
        unique case (acc_q)
            ACC_LO:  load_val = {{BUS_W{1'b0}}, wdata};
            ACC_HI:  load_val = {wdata, {BUS_W{1'b0}}};
            default: load_val = {wdata, lo_stage_q};
        endcase
        load_req = data_wr && !cfg_wr && ((acc_q != ACC_WORD) || wr_hi_q);
    end

    // Read byte selection from snapshot or live count.
    always_comb begin
        rd_src   = frozen_q ? snap_q : live_cnt;
        rd_upper = (acc_q == ACC_HI) || ((acc_q == ACC_WORD) && rd_hi_q);
        rd_byte  = rd_upper ? rd_src[CNT_W-1:BUS_W] : rd_src[BUS_W-1:0];
    end

    // Access pattern, byte-order flops, staging and snapshot state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= ACC_WORD;
            wr_hi_q    <= 1'b0;
            rd_hi_q    <= 1'b0;
            lo_stage_q <= '0;
            frozen_q   <= 1'b0;
            snap_q     <= '0;
        end else if (cfg_wr) begin
            acc_q    <= cfg_acc;
            wr_hi_q  <= 1'b0;
            rd_hi_q  <= 1'b0;
            frozen_q <= 1'b0;
        end else begin
            if (data_wr && (acc_q == ACC_WORD)) begin
                wr_hi_q <= !wr_hi_q;
                if (!wr_hi_q) lo_stage_q <= wdata;
            end
            if (data_rd) begin
                if (acc_q == ACC_WORD) rd_hi_q <= !rd_hi_q;
                if ((acc_q != ACC_WORD) || rd_hi_q) frozen_q <= 1'b0;
            end
            if (freeze_cmd && !frozen_q) begin
                frozen_q <= 1'b1;
                snap_q   <= live_cnt;
            end
        end
    end

endmodule

// File: rtl/pit_count_core.sv
`timescale 1ns/1ps
// pit_count_core: the count register and output pin of one counter.
// Assumes tick is a one-clock enable; a new count waits for a tick,
// and the gate is sampled on the system clock.
module pit_count_core
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  mode_e            cfg_mode,
    input  logic             cfg_dec,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             gate,
    output logic [CNT_W-1:0] cnt,
    output logic             out
);

    mode_e            mode_q;
    logic             dec_q;
    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] cnt_q;
    logic             out_q;
    logic             armed_q;
    logic             pend_q;
    logic             regate_q;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] half;
    logic             periodic;

    // Next count, square-wave toggle point and mode class.
    always_comb begin
        nxt      = count_down(cnt_q, dec_q);
        half     = count_half(init_q, dec_q);
        periodic = (mode_q != MD_EVENT);
    end

    // Mode, load, gate and counting sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MD_EVENT;
            dec_q    <= 1'b0;
            init_q   <= '0;
            cnt_q    <= '0;
            out_q    <= 1'b1;
            armed_q  <= 1'b0;
            pend_q   <= 1'b0;
            regate_q <= 1'b0;
        end else if (cfg_wr) begin
            mode_q   <= cfg_mode;
            dec_q    <= cfg_dec;
            armed_q  <= 1'b0;
            pend_q   <= 1'b0;
            regate_q <= 1'b0;
            out_q    <= (cfg_mode != MD_EVENT);
        end else begin
            if (load_req) begin
                pend_q <= 1'b1;
                init_q <= load_val;
            end
            if (periodic && !gate) begin
                out_q    <= 1'b1;
                regate_q <= 1'b1;
            end else if (tick) begin
                if (pend_q) begin
                    cnt_q    <= init_q;
                    armed_q  <= 1'b1;
                    pend_q   <= load_req;
                    regate_q <= 1'b0;
                    out_q    <= periodic;
                end else if (armed_q && regate_q) begin
                    cnt_q    <= init_q;
                    regate_q <= 1'b0;
                    out_q    <= 1'b1;
                end else if (armed_q && (periodic || gate)) begin
                    unique case (mode_q)
                        MD_EVENT: begin
                            cnt_q <= nxt;
                            if (nxt == '0) out_q <= 1'b1;
                        end
                        MD_STROBE: begin
                            if (cnt_q == CNT_W'(1)) begin
                                cnt_q <= init_q;
                                out_q <= 1'b1;
                            end else begin
                                cnt_q <= nxt;
                                if (cnt_q == CNT_W'(2)) out_q <= 1'b0;
                            end
                        end
                        default: begin
                            if (cnt_q == CNT_W'(1)) begin
                                cnt_q <= init_q;
                                out_q <= 1'b1;
                            end else begin
                                cnt_q <= nxt;
                                if (nxt == half) out_q <= 1'b0;
                            end
                        end
                    endcase
                end
            end
        end
    end

    assign cnt = cnt_q;
    assign out = out_q;

endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
// pit_timer: top of the interval timer. One bus decoder feeds NUM_CH
// counter channels, each a byte port plus a count core; read data is
// muxed by address. Assumes NUM_CH is 1 to 3 (the select field has room
// for three counters, and address 3 is always the control port).
module pit_timer
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic [NUM_CH-1:0] cnt_tick,
    input  logic [NUM_CH-1:0] cnt_gate,
    output logic [NUM_CH-1:0] cnt_out
);

    logic [NUM_CH-1:0] cfg_wr;
    logic [NUM_CH-1:0] freeze_cmd;
    logic [NUM_CH-1:0] data_wr;
    logic [NUM_CH-1:0] data_rd;
    acc_e              cfg_acc;
    mode_e             cfg_mode;
    logic              cfg_dec;
    logic [BUS_W-1:0]  ch_rd [NUM_CH];

    pit_bus_decode #(.NUM_CH(NUM_CH)) u_decode (
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .cfg_wr     (cfg_wr),
        .freeze_cmd (freeze_cmd),
        .data_wr    (data_wr),
        .data_rd    (data_rd),
        .cfg_acc    (cfg_acc),
        .cfg_mode   (cfg_mode),
        .cfg_dec    (cfg_dec)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic             load_req;
        logic [CNT_W-1:0] load_val;
        logic [CNT_W-1:0] live_cnt;

        pit_byte_port u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_wr     (cfg_wr[g]),
            .cfg_acc    (cfg_acc),
            .freeze_cmd (freeze_cmd[g]),
            .data_wr    (data_wr[g]),
            .data_rd    (data_rd[g]),
            .wdata      (bus_wdata),
            .live_cnt   (live_cnt),
            .load_req   (load_req),
            .load_val   (load_val),
            .rd_byte    (ch_rd[g])
        );

        pit_count_core u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_wr   (cfg_wr[g]),
            .cfg_mode (cfg_mode),
            .cfg_dec  (cfg_dec),
            .load_req (load_req),
            .load_val (load_val),
            .tick     (cnt_tick[g]),
            .gate     (cnt_gate[g]),
            .cnt      (live_cnt),
            .out      (cnt_out[g])
        );
    end

    // Read mux: data ports by address, zero for control or absent counters.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == 2'(i)) bus_rdata = ch_rd[i];
        end
    end

endmodule

// File: rtl/pit_timer_chk.sv
`timescale 1ns/1ps
// pit_timer_chk: port-level properties of the interval timer, bound to
// every pit_timer instance.
module pit_timer_chk #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic [NUM_CH-1:0] cnt_tick,
    input logic [NUM_CH-1:0] cnt_gate,
    input logic [NUM_CH-1:0] cnt_out
);

    // R1: the control address never returns data.
    assert_ctrl_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // R7: a terminal-count control byte pulls the output low.
        assert_event_ctrl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == 2'(g) &&
             bus_wdata[5:4] != 2'b00 && bus_wdata[3:1] == 3'd0) |=> !cnt_out[g]);

        // R8, R9: a periodic or square-wave control byte drives the output high.
        assert_periodic_ctrl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == 2'(g) &&
             bus_wdata[5:4] != 2'b00 && bus_wdata[2]) |=> cnt_out[g]);

        // R12: the output is quiet without tick, write or gate change.
        assert_out_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_tick[g] && !bus_wr && $stable(cnt_gate[g])) |=> $stable(cnt_out[g]));
    end

endmodule

bind pit_timer pit_timer_chk #(.NUM_CH(NUM_CH)) u_pit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .cnt_tick  (cnt_tick),
    .cnt_gate  (cnt_gate),
    .cnt_out   (cnt_out)
);

// File: tb/test_pit_timer.sv
`timescale 1ns/1ps
module test_pit_timer;

    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [7:0]     bus_rdata;
    logic [NCH-1:0] cnt_tick = '0;
    logic [NCH-1:0] cnt_gate = '1;
    logic [NCH-1:0] cnt_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pit_timer #(.NUM_CH(NCH)) i_pit_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cnt_tick(cnt_tick), .cnt_gate(cnt_gate), .cnt_out(cnt_out)
    );

    // op: 0 write, 1 read and compare, 2 ticks on counter <addr>
    localparam int NV = 29;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 2'd3, 8'h34, 8'h00}, {2'd0, 2'd0, 8'h34, 8'h00}, {2'd0, 2'd0, 8'h12, 8'h00},
        {2'd2, 2'd0, 8'h03, 8'h00}, {2'd0, 2'd3, 8'h00, 8'h00}, {2'd2, 2'd0, 8'h03, 8'h00},
        {2'd1, 2'd0, 8'h00, 8'h32}, {2'd1, 2'd0, 8'h00, 8'h12}, {2'd1, 2'd0, 8'h00, 8'h2F},
        {2'd1, 2'd0, 8'h00, 8'h12}, {2'd0, 2'd3, 8'h00, 8'h00}, {2'd2, 2'd0, 8'h01, 8'h00},
        {2'd0, 2'd3, 8'h00, 8'h00}, {2'd2, 2'd0, 8'h01, 8'h00}, {2'd1, 2'd0, 8'h00, 8'h2F},
        {2'd1, 2'd0, 8'h00, 8'h12}, {2'd1, 2'd0, 8'h00, 8'h2D}, {2'd1, 2'd0, 8'h00, 8'h12},
        {2'd1, 2'd0, 8'h00, 8'h2D}, {2'd0, 2'd3, 8'h34, 8'h00}, {2'd2, 2'd0, 8'h02, 8'h00},
        {2'd1, 2'd0, 8'h00, 8'h2D}, {2'd1, 2'd0, 8'h00, 8'h12}, {2'd0, 2'd3, 8'h14, 8'h00},
        {2'd1, 2'd0, 8'h00, 8'h2D}, {2'd1, 2'd0, 8'h00, 8'h2D}, {2'd0, 2'd3, 8'h24, 8'h00},
        {2'd1, 2'd0, 8'h00, 8'h12}, {2'd1, 2'd0, 8'h00, 8'h12}
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 chk(16'(bus_rdata), 16'(e), tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int ch, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cnt_tick[ch] = 1'b1;
            @(negedge clk); cnt_tick[ch] = 1'b0;
        end
    endtask

    task automatic out_is(input int ch, input logic e, input string tag);
        #1 chk(16'(cnt_out[ch]), 16'(e), tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and control-port read
        #1 chk(16'(cnt_out), 16'h7, "R1 reset outputs");
        brd(2'd0, 8'h00, "R1 reset count");
        brd(2'd3, 8'h00, "R1 control read");

        // R3 R4 R6: access patterns and snapshot sequence on counter 0
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][19:18])
                2'd0: bwr(VEC[i][17:16], VEC[i][15:8]);
                2'd1: brd(VEC[i][17:16], VEC[i][7:0], $sformatf("R3/R4/R6 vector %0d", i));
                default: ticks(int'(VEC[i][17:16]), int'(VEC[i][15:8]));
            endcase
        end

        // R3 R5: high-byte-only write on counter 0
        bwr(2'd0, 8'h01);
        ticks(0, 1);
        brd(2'd0, 8'h01, "R5 load on tick, R3 high only");
        ticks(0, 1);
        brd(2'd0, 8'h00, "R3 high byte of 00FF");

        // R7: terminal-count mode on counter 1, low byte only, gate pause
        bwr(2'd3, 8'h50);
        out_is(1, 1'b0, "R7 low after control");
        bwr(2'd1, 8'h05);
        ticks(1, 1);
        brd(2'd1, 8'h05, "R5 count entered");
        cnt_gate[1] = 1'b0;
        ticks(1, 3);
        brd(2'd1, 8'h05, "R7 gate low holds");
        cnt_gate[1] = 1'b1;
        ticks(1, 4);
        out_is(1, 1'b0, "R7 still low at count 1");
        ticks(1, 1);
        out_is(1, 1'b1, "R7 high at zero");
        ticks(1, 2);
        out_is(1, 1'b1, "R7 stays high");
        brd(2'd1, 8'hFE, "R7 wraps on");

        // R2: unsupported mode and unused select have no effect
        bwr(2'd3, 8'h52);
        out_is(1, 1'b1, "R2 mode 1 ignored out");
        brd(2'd1, 8'hFE, "R2 mode 1 ignored count");
        ticks(1, 1);
        brd(2'd1, 8'hFD, "R2 still counting");
        bwr(2'd3, 8'hD0);
        out_is(1, 1'b1, "R2 select 11 ignored out");
        brd(2'd1, 8'hFD, "R2 select 11 ignored count");

        // R8: periodic strobe on counter 2, word access, count 3
        bwr(2'd3, 8'hB4);
        bwr(2'd2, 8'h03);
        bwr(2'd2, 8'h00);
        ticks(2, 2);
        out_is(2, 1'b1, "R8 high at count 2");
        ticks(2, 1);
        out_is(2, 1'b0, "R8 low at count 1");
        ticks(2, 1);
        out_is(2, 1'b1, "R8 high after reload");
        ticks(2, 2);
        out_is(2, 1'b0, "R8 period of 3");

        // R10: gate low forces high and holds; rise then reload
        @(negedge clk); cnt_gate[2] = 1'b0;
        @(negedge clk);
        out_is(2, 1'b1, "R10 gate forces high");
        ticks(2, 2);
        brd(2'd2, 8'h01, "R10 count held low byte");
        brd(2'd2, 8'h00, "R10 count held high byte");
        cnt_gate[2] = 1'b1;
        ticks(2, 1);
        brd(2'd2, 8'h03, "R10 reload low byte");
        brd(2'd2, 8'h00, "R10 reload high byte");

        // R9 R2: square wave via alias code 7, odd count 5
        bwr(2'd3, 8'h9E);
        bwr(2'd2, 8'h05);
        ticks(2, 3);
        out_is(2, 1'b1, "R9 odd high third tick");
        ticks(2, 1);
        out_is(2, 1'b0, "R9 odd low");
        ticks(2, 1);
        out_is(2, 1'b0, "R9 odd low second");
        ticks(2, 1);
        out_is(2, 1'b1, "R9 odd high again");
        // R9: even count 4
        bwr(2'd3, 8'h96);
        bwr(2'd2, 8'h04);
        ticks(2, 2);
        out_is(2, 1'b1, "R9 even high");
        ticks(2, 1);
        out_is(2, 1'b0, "R9 even low");
        ticks(2, 2);
        out_is(2, 1'b1, "R9 even high again");

        // R11: decimal stepping and zero loads
        bwr(2'd3, 8'h71);
        bwr(2'd1, 8'h10);
        bwr(2'd1, 8'h00);
        ticks(1, 2);
        brd(2'd1, 8'h09, "R11 decimal 10 to 09");
        brd(2'd1, 8'h00, "R11 decimal high byte");
        bwr(2'd3, 8'h71);
        bwr(2'd1, 8'h00);
        bwr(2'd1, 8'h00);
        ticks(1, 2);
        brd(2'd1, 8'h99, "R11 decimal wrap low");
        brd(2'd1, 8'h99, "R11 decimal wrap high");
        bwr(2'd3, 8'h70);
        bwr(2'd1, 8'h00);
        bwr(2'd1, 8'h00);
        ticks(1, 2);
        brd(2'd1, 8'hFF, "R11 binary wrap low");
        brd(2'd1, 8'hFF, "R11 binary wrap high");
        // R11 R9: decimal square wave of 10
        bwr(2'd3, 8'h57);
        bwr(2'd1, 8'h10);
        ticks(1, 5);
        out_is(1, 1'b1, "R9 decimal high half");
        ticks(1, 1);
        out_is(1, 1'b0, "R11 decimal half point");
        ticks(1, 4);
        out_is(1, 1'b0, "R9 decimal low half");
        ticks(1, 1);
        out_is(1, 1'b1, "R9 decimal reload");

        done = 1'b1;
        finish_run();
    end

endmodule